// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns a compact predicate selection into two 64-bit element masks, one for the destination side and one for the source side of a vector operation. In integer mode a three-bit code picks a mask built from one of three scalar register values that arrive on ports. The code can select "every element", a single element chosen by a register value, a register value as given, or a register value with every bit inverted. In condition mode the same code picks one flag bit and a polarity. The block then tests that flag in a run of 4-bit condition fields, one field per element, up to the active vector length.

The caller presents a full request and pulses `start`. One clock later both masks appear on registered outputs and `valid` is high for that single cycle. The masks then hold until the next request. With twin predication off, the source mask copies the destination mask. With it on, the source mask is decoded from its own code, using the same mode and the same operands.

Top module: `pred_mask_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request, `valid` is 0 and both masks are 0.
- R2: A cycle with `start` high loads both masks at the next rising edge, and `valid` is 1 for exactly that one following cycle. When `start` is low, `valid` is 0 in the following cycle and both masks keep their values whatever the inputs do.
- R3: When `pred_mode` is 0 (none) or 3 (reserved, treated the same as none), both masks are all ones.
- R4: With `pred_mode` = 1 (integer), code 0 gives an all-ones mask.
- R5: With `pred_mode` = 1, code 1 gives a one-hot mask whose single 1 sits at bit position `reg_x[5:0]`. Bits 63..6 of `reg_x` have no effect.
- R6: With `pred_mode` = 1, codes 2 through 7 give, in order: `reg_x`, `~reg_x`, `reg_y`, `~reg_y`, `reg_z`, `~reg_z`.
- R7: With `pred_mode` = 2 (condition), the code selects flag bit `code[2:1]` of each field. A field qualifies when that bit equals `~code[0]`. Codes 0..7 are therefore: bit0 set, bit0 clear, bit1 set, bit1 clear, bit2 set, bit2 clear, bit3 set, bit3 clear. Field i is `cr_fields[4*i+3:4*i]`, and flag bit k of a field is that field's bit k.
- R8: In condition mode, mask bit i is 1 only if i < `vec_len` and field i qualifies. Bits at `vec_len` and above are 0. A `vec_len` of 64 or more covers every element, and a `vec_len` of 0 gives an all-zero mask.
- R9: When `twin` is 0 the source mask equals the destination mask, which is decoded from `dst_code`. When `twin` is 1 the source mask is decoded from `src_code` under the same mode and operands, and `src_code` has no effect when `twin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe; all other inputs are sampled in this cycle |
| pred_mode | input | 2 | 0 none, 1 integer, 2 condition, 3 treated as none |
| twin | input | 1 | 1 selects separate source predicate decoding |
| dst_code | input | 3 | Destination predicate code |
| src_code | input | 3 | Source predicate code, used only when twin is 1 |
| reg_x | input | 64 | First scalar register operand (also gives the unary index) |
| reg_y | input | 64 | Second scalar register operand |
| reg_z | input | 64 | Third scalar register operand |
| vec_len | input | 7 | Active vector length in elements |
| cr_fields | input | 256 | 64 condition fields of 4 bits, field i at bits 4i+3..4i |
| valid | output | 1 | One-cycle pulse: masks updated from the previous cycle's request |
| dst_mask | output | 64 | Destination element mask |
| src_mask | output | 64 | Source element mask |

## Verification
Every result is due exactly one rising edge after the cycle in which `start` is high: `valid`, `dst_mask` and `src_mask` all come from that one register stage. The bench drives each request on a falling edge, compares all three outputs on the next falling edge against bench-computed values, and then drops `start` and scrambles every input. On the following falling edge it checks that `valid` has fallen and both masks are unchanged, which shows the hold behaviour. Random requests mix all four modes, both twin settings and lengths beyond 64. Directed cases cover unary index wrap, zero and full vector lengths, and the reserved mode.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INT  = 2'd1,
    PM_COND = 2'd2,
    PM_RSVD = 2'd3
  } pm_mode_e;

  typedef enum logic [2:0] {
    IC_ALL   = 3'd0,
    IC_UNARY = 3'd1,
    IC_X     = 3'd2,
    IC_X_INV = 3'd3,
    IC_Y     = 3'd4,
    IC_Y_INV = 3'd5,
    IC_Z     = 3'd6,
    IC_Z_INV = 3'd7
  } pm_int_code_e;

  typedef struct packed {
    logic [1:0] flag;  // which bit inside each condition field
    logic       want;  // value that bit must hold
  } pm_cond_sel_t;

  // condition code: upper two bits pick the flag, lsb clear means "flag set"
  function automatic pm_cond_sel_t pm_cond_decode(input logic [2:0] code);
    pm_cond_sel_t s;
    s.flag = code[2:1];
    s.want = ~code[0];
    return s;
  endfunction

endpackage

// File: rtl/pm_int_decode.sv
module pm_int_decode
  import pm_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic [2:0]        code,
  input  logic [MASK_W-1:0] reg_x,
  input  logic [MASK_W-1:0] reg_y,
  input  logic [MASK_W-1:0] reg_z,
  output logic [MASK_W-1:0] mask
);

  function automatic logic [MASK_W-1:0] int_mask(
    input logic [2:0]        c,
    input logic [MASK_W-1:0] x,
    input logic [MASK_W-1:0] y,
    input logic [MASK_W-1:0] z
  );
    logic [MASK_W-1:0] one;
    one = {{(MASK_W-1){1'b0}}, 1'b1};
    case (pm_int_code_e'(c))
      IC_ALL:   return '1;
      IC_UNARY: return one << x[IDX_W-1:0];
      IC_X:     return x;
      IC_X_INV: return ~x;
      IC_Y:     return y;
      IC_Y_INV: return ~y;
      IC_Z:     return z;
      default:  return ~z;
    endcase
  endfunction

  assign mask = int_mask(code, reg_x, reg_y, reg_z);

endmodule

// File: rtl/pm_cond_gather.sv
module pm_cond_gather
  import pm_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int FIELD_W = 4,
  localparam int VL_W   = $clog2(MASK_W) + 1,
  localparam int CR_W   = MASK_W * FIELD_W
) (
  input  logic [2:0]        code,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [CR_W-1:0]   cr_fields,
  output logic [MASK_W-1:0] mask
);

  pm_cond_sel_t sel;
  assign sel = pm_cond_decode(code);

  for (genvar i = 0; i < MASK_W; i++) begin : g_elem
    localparam logic [VL_W-1:0] ELEM = VL_W'(i);
    logic [FIELD_W-1:0] fld;
    logic               in_len;
    logic               hit;
    assign fld    = cr_fields[i*FIELD_W +: FIELD_W];
    assign in_len = ELEM < vec_len;
    assign hit    = fld[sel.flag] == sel.want;
    assign mask[i] = in_len & hit;
  end

endmodule

// File: rtl/pm_lane.sv
module pm_lane
  import pm_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int FIELD_W = 4,
  localparam int VL_W   = $clog2(MASK_W) + 1,
  localparam int CR_W   = MASK_W * FIELD_W
) (
  input  logic [1:0]        pred_mode,
  input  logic [2:0]        code,
  input  logic [MASK_W-1:0] reg_x,
  input  logic [MASK_W-1:0] reg_y,
  input  logic [MASK_W-1:0] reg_z,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [CR_W-1:0]   cr_fields,
  output logic [MASK_W-1:0] mask
);

  logic [MASK_W-1:0] int_m;
  logic [MASK_W-1:0] cond_m;

  pm_int_decode #(.MASK_W(MASK_W)) u_int (
    .code  (code),
    .reg_x (reg_x),
    .reg_y (reg_y),
    .reg_z (reg_z),
    .mask  (int_m)
  );

  pm_cond_gather #(.MASK_W(MASK_W), .FIELD_W(FIELD_W)) u_cond (
    .code      (code),
    .vec_len   (vec_len),
    .cr_fields (cr_fields),
    .mask      (cond_m)
  );

  always_comb begin
    case (pm_mode_e'(pred_mode))
      PM_INT:  mask = int_m;
      PM_COND: mask = cond_m;
      default: mask = '1;
    endcase
  end

endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pm_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int FIELD_W = 4,
  localparam int VL_W   = $clog2(MASK_W) + 1,
  localparam int CR_W   = MASK_W * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        pred_mode,
  input  logic              twin,
  input  logic [2:0]        dst_code,
  input  logic [2:0]        src_code,
  input  logic [MASK_W-1:0] reg_x,
  input  logic [MASK_W-1:0] reg_y,
  input  logic [MASK_W-1:0] reg_z,
  input  logic [VL_W-1:0]   vec_len,
  input  logic [CR_W-1:0]   cr_fields,
  output logic              valid,
  output logic [MASK_W-1:0] dst_mask,
  output logic [MASK_W-1:0] src_mask
);

  localparam int NLANE = 2;  // lane 0: destination, lane 1: source

  logic [MASK_W-1:0] lane_mask [NLANE];
  logic [MASK_W-1:0] dst_nxt;
  logic [MASK_W-1:0] src_nxt;
  logic              load;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [2:0] lane_code;
    if (g == 0) begin : g_dst
      assign lane_code = dst_code;
    end else begin : g_src
      assign lane_code = src_code;
    end
    pm_lane #(.MASK_W(MASK_W), .FIELD_W(FIELD_W)) u_lane (
      .pred_mode (pred_mode),
      .code      (lane_code),
      .reg_x     (reg_x),
      .reg_y     (reg_y),
      .reg_z     (reg_z),
      .vec_len   (vec_len),
      .cr_fields (cr_fields),
      .mask      (lane_mask[g])
    );
  end

  assign load    = start;
  assign dst_nxt = lane_mask[0];
  assign src_nxt = twin ? lane_mask[1] : lane_mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      dst_mask <= '0;
      src_mask <= '0;
    end else begin
      valid <= load;
      if (load) begin
        dst_mask <= dst_nxt;
        src_mask <= src_nxt;
      end
    end
  end

endmodule

// File: rtl/pred_mask_gen_chk.sv
module pred_mask_gen_chk #(
  parameter int MASK_W = 64,
  parameter int VL_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        pred_mode,
  input logic              twin,
  input logic [2:0]        dst_code,
  input logic [VL_W-1:0]   vec_len,
  input logic              valid,
  input logic [MASK_W-1:0] dst_mask,
  input logic [MASK_W-1:0] src_mask
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);  // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);  // R2

  AST_MASKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(dst_mask) && $stable(src_mask)));  // R2

  AST_NONE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (pred_mode == 2'd0 || pred_mode == 2'd3)) |=> (&dst_mask && &src_mask));  // R3

  AST_UNARY_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pred_mode == 2'd1 && dst_code == 3'd1) |=> ($countones(dst_mask) == 1));  // R5

  AST_COND_ABOVE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pred_mode == 2'd2 && vec_len < VL_W'(MASK_W))
      |=> ((dst_mask >> $past(vec_len)) == '0));  // R8

  AST_SINGLE_PRED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !twin) |=> (src_mask == dst_mask));  // R9

endmodule

bind pred_mask_gen pred_mask_gen_chk #(.MASK_W(MASK_W), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pred_mode (pred_mode),
  .twin      (twin),
  .dst_code  (dst_code),
  .vec_len   (vec_len),
  .valid     (valid),
  .dst_mask  (dst_mask),
  .src_mask  (src_mask)
);

// File: tb/pred_mask_gen_bench.sv
module pred_mask_gen_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   pred_mode = '0;
  logic         twin = 1'b0;
  logic [2:0]   dst_code = '0;
  logic [2:0]   src_code = '0;
  logic [63:0]  reg_x = '0;
  logic [63:0]  reg_y = '0;
  logic [63:0]  reg_z = '0;
  logic [6:0]   vec_len = '0;
  logic [255:0] cr_fields = '0;
  logic         valid;
  logic [63:0]  dst_mask;
  logic [63:0]  src_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pred_mask_gen u_pred_mask_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .pred_mode(pred_mode),
    .twin(twin), .dst_code(dst_code), .src_code(src_code),
    .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z), .vec_len(vec_len),
    .cr_fields(cr_fields), .valid(valid), .dst_mask(dst_mask),
    .src_mask(src_mask)
  );

  // reference model written from the requirements
  function automatic logic [63:0] ref_mask(input logic [1:0] m, input logic [2:0] c,
      input logic [63:0] x, input logic [63:0] y, input logic [63:0] z,
      input logic [6:0] vl, input logic [255:0] cr);
    logic [63:0] r;
    r = '1;
    if (m == 2'd1) begin
      case (c)
        3'd0: r = '1;
        3'd1: begin r = '0; r[x % 64] = 1'b1; end
        3'd2: r = x;
        3'd3: r = ~x;
        3'd4: r = y;
        3'd5: r = ~y;
        3'd6: r = z;
        default: r = ~z;
      endcase
    end else if (m == 2'd2) begin
      r = '0;
      for (int i = 0; i < 64; i++) begin
        int k;
        k = c / 2;
        if (i < int'(vl) && cr[4*i + k] == (c % 2 == 0)) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk1(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    pred_mode = 2'($urandom);
    twin      = 1'($urandom);
    dst_code  = 3'($urandom);
    src_code  = 3'($urandom);
    reg_x     = {$urandom, $urandom};
    reg_y     = {$urandom, $urandom};
    reg_z     = {$urandom, $urandom};
    vec_len   = 7'($urandom);
    for (int w = 0; w < 8; w++) cr_fields[32*w +: 32] = $urandom;
  endtask

  // drive on a falling edge; results due one rising edge later
  task automatic apply(input string req);
    logic [63:0] e_dst, e_src;
    e_dst = ref_mask(pred_mode, dst_code, reg_x, reg_y, reg_z, vec_len, cr_fields);
    e_src = twin ? ref_mask(pred_mode, src_code, reg_x, reg_y, reg_z, vec_len, cr_fields)
                 : e_dst;
    start = 1'b1;
    @(negedge clk);
    chk1({req, " R2 valid"}, {63'd0, valid}, 64'd1);
    chk1({req, " dst"}, dst_mask, e_dst);
    chk1({req, " src R9"}, src_mask, e_src);
    start = 1'b0;
    scramble();
    @(negedge clk);
    chk1("R2 valid drop", {63'd0, valid}, 64'd0);
    chk1("R2 dst hold", dst_mask, e_dst);
    chk1("R2 src hold", src_mask, e_src);
  endtask

  task automatic setup(input logic [1:0] m, input logic tw, input logic [2:0] dc,
                       input logic [2:0] sc, input logic [6:0] vl);
    pred_mode = m; twin = tw; dst_code = dc; src_code = sc; vec_len = vl;
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    chk1("R1 valid in reset", {63'd0, valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1 valid", {63'd0, valid}, 64'd0);
    chk1("R1 dst", dst_mask, 64'd0);
    chk1("R1 src", src_mask, 64'd0);

    // directed corners
    scramble(); setup(2'd0, 1'b1, 3'd2, 3'd5, 7'd3);  apply("R3 none");
    scramble(); setup(2'd3, 1'b0, 3'd6, 3'd1, 7'd9);  apply("R3 reserved");
    scramble(); setup(2'd1, 1'b0, 3'd0, 3'd0, 7'd0);  apply("R4 all");
    scramble(); setup(2'd1, 1'b0, 3'd1, 3'd0, 7'd0);
    reg_x = 64'hFFFF_FFFF_FFFF_FFFF;                   apply("R5 unary 63");
    scramble(); setup(2'd1, 1'b1, 3'd1, 3'd3, 7'd0);
    reg_x = 64'h0000_0000_0000_0045;                   apply("R5 unary wrap");
    for (int c = 2; c < 8; c++) begin
      scramble(); setup(2'd1, 1'b1, 3'(c), 3'(9 - c), 7'd0); apply("R6 regsel");
    end
    for (int c = 0; c < 8; c++) begin
      scramble(); setup(2'd2, 1'b1, 3'(c), 3'(7 - c), 7'd64); apply("R7 cond code");
    end
    scramble(); setup(2'd2, 1'b0, 3'd0, 3'd0, 7'd0);
    cr_fields = '1;                                    apply("R8 len zero");
    scramble(); setup(2'd2, 1'b0, 3'd0, 3'd0, 7'd127);
    cr_fields = '1;                                    apply("R8 len over");
    scramble(); setup(2'd2, 1'b0, 3'd7, 3'd0, 7'd17);
    cr_fields = '0;                                    apply("R8 len 17");
    scramble(); setup(2'd1, 1'b0, 3'd2, 3'd7, 7'd0);  apply("R9 single");

    // random mix
    for (int n = 0; n < 400; n++) begin
      scramble();
      if (n % 5 == 0) vec_len = 7'(64 + $urandom % 64);
      apply("R7 R8 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule